// File: doc/BRIEF.md
# Memory Scrubbing CRC Error Monitor

This block watches a memory region for silent corruption while the rest of the chip keeps running. After initialization it reads the region one 32-bit word per check tick and folds every word into a CRC-32. At the end of the pass it compares the result against a reference value captured before checking began. When the two differ, the block reads the region a second time and looks for the first word whose stored parity bit no longer matches its contents. It then raises an active-high error output and records the location in a message register. Passes repeat back to back until reset.

Check ticks come from a base clock divided by a power of two. The power is chosen at reset. To let a test force one known error, a 21-bit injection field can be written to a shadow register through a small parallel test port. An update strobe copies the shadow into a working register. The next pass then flips the chosen bit of the chosen word on every read.

Top module: `scrub_crc_monitor`

## Requirements
- R1: While `init_done` is low after reset, no checking takes place: `err_o` stays low and `mem_addr` stays 0. Once `init_done` is seen high on a check tick, passes start on their own.
- R2: The pass CRC is CRC-32, polynomial 0x04C11DB7, not reflected, initial value 0xFFFFFFFF, no final inversion. Each word is fed most significant bit first, in address order 0 to 2^ADDR_W-1. The reference comes from `ref_crc` and is captured while the block is idle. A mismatch leads to a location search; a match leaves `err_o` low.
- R3: `err_o` goes low on the tick that consumes the last word of a pass. When the pass is in error, it rises exactly (32+k)·D base cycles later. Here D is the divisor and k is the index of the word at which the search stops, so the low time is never shorter than 31 ticks.
- R4: The search stops at the first word whose XOR-reduced data differs from `mem_par`, or at the last word if none differs. `err_o` rises on that tick.
- R5: D = 2^n, where n is `div_sel` sampled while `rst` is high. Values below 1 are clamped to 1 and values above 8 are clamped to 8.
- R6: The injection field holds the word address in bits [20:5] and the bit index in bits [4:0]. `tst_wr` writes the shadow and `tst_upd` copies it to the working register and arms it. The pass that starts next applies the flip to every read of that word. The injection is then disarmed.
- R7: Every search updates the message register. `msg_valid` is set when a parity mismatch was located and `msg_addr` takes that word address; otherwise both become 0. The values hold until the next search.
- R8: Passes continue without end. A new pass starts right after a search ends, or 31 ticks after a matching pass. A new scan lasts 2^ADDR_W ticks. A clean pass that follows a faulty one drives `err_o` low and keeps it low.
- R9: Synchronous active-high reset clears `err_o`, `msg_valid` and `msg_addr`.
- R10: Writing the shadow without an update strobe has no effect on the data checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Initialization complete, user operation begun |
| div_sel | input | 4 | Divider exponent n, sampled during reset |
| ref_crc | input | 32 | Reference CRC of the region |
| mem_addr | output | ADDR_W | Word address being read |
| mem_rdata | input | 32 | Word at `mem_addr`, same cycle |
| mem_par | input | 1 | Stored even parity of the word at `mem_addr` |
| tst_wr | input | 1 | Write strobe for the injection shadow |
| tst_wdata | input | 21 | Injection field {address[15:0], bit[4:0]} |
| tst_upd | input | 1 | Copy shadow to working register and arm |
| err_o | output | 1 | Active-high error output |
| msg_valid | output | 1 | Message holds a located word |
| msg_addr | output | ADDR_W | Located word address |

## Verification
Every result is tied to a check tick, one every D base cycles. The bench therefore measures intervals between edges of `err_o` rather than absolute times. A scan lasts 2^ADDR_W·D cycles from rise to fall. From fall to rise takes (32+k)·D cycles, with k the stopping word. The message register is read on the negative edge after each rise, because it changes on the same edge as `err_o`. The "no effect" and "stays low" cases are checked by sampling `err_o` on every cycle of a window that spans several full passes.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    localparam int WORD_W      = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam int INJ_W       = 21;
    localparam int INJ_ADDR_W  = 16;
    localparam int BIT_IDX_W   = 5;
    localparam int DIV_SEL_W   = 4;
    localparam int MIN_EXP     = 1;
    localparam int MAX_EXP     = 8;
    localparam int LOW_TICKS   = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_LOWP,
        ST_SEARCH
    } scrub_state_e;

    typedef struct packed {
        logic [INJ_ADDR_W-1:0] addr;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } inj_field_t;

    // One word folded into the running CRC, most significant bit first.
    function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] c,
                                                   input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        logic fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[WORD_W-1] ^ d[i];
            r  = {r[WORD_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic logic [DIV_SEL_W-1:0] clamp_exp(input logic [DIV_SEL_W-1:0] s);
        if (s < DIV_SEL_W'(MIN_EXP)) return DIV_SEL_W'(MIN_EXP);
        if (s > DIV_SEL_W'(MAX_EXP)) return DIV_SEL_W'(MAX_EXP);
        return s;
    endfunction

endpackage

// File: rtl/scrub_clk_div.sv
module scrub_clk_div
    import scrub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    localparam int CNT_W = MAX_EXP;

    logic [DIV_SEL_W-1:0] exp_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     lim;

    assign lim  = CNT_W'((32'd1 << exp_q) - 32'd1);
    assign tick = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= clamp_exp(div_sel);
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the divisor is at least two, so ticks are never adjacent
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/scrub_fault_inj.sv
module scrub_fault_inj
    import scrub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tst_wr,
    input  logic [INJ_W-1:0] tst_wdata,
    input  logic             tst_upd,
    input  logic             pass_start,
    output logic             act_en,
    output inj_field_t       act_fld
);

    inj_field_t shadow_q;
    inj_field_t work_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            work_q   <= '0;
            armed_q  <= 1'b0;
            act_en   <= 1'b0;
            act_fld  <= '0;
        end else begin
            if (tst_wr) shadow_q <= inj_field_t'(tst_wdata);
            if (tst_upd) begin
                work_q  <= shadow_q;
                armed_q <= 1'b1;
            end else if (pass_start) begin
                armed_q <= 1'b0;
            end
            if (pass_start) begin
                act_en  <= armed_q;
                act_fld <= work_q;
            end
        end
    end

    // R6: an update strobe moves the shadow contents to the working register
    p_upd_copy_r6: assert property (@(posedge clk) disable iff (rst)
        tst_upd |=> (work_q == $past(shadow_q)));

    // R6: a pass start without a fresh strobe leaves nothing armed
    p_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
        (pass_start && !tst_upd) |=> !armed_q);

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              init_done,
    input  logic [WORD_W-1:0] ref_crc,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_par,
    input  logic              inj_en,
    input  inj_field_t        inj_fld,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pass_start,
    output logic              err_o,
    output logic              msg_valid,
    output logic [ADDR_W-1:0] msg_addr
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam int LOW_W = $clog2(LOW_TICKS + 1);

    scrub_state_e      state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] ref_q;
    logic              mism_q;
    logic [LOW_W-1:0]  low_q;

    logic [WORD_W-1:0] flip_mask;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] crc_nxt;
    logic              par_bad;
    logic              addr_last;
    logic              low_done;
    logic              search_done;

    assign mem_addr    = addr_q;
    assign flip_mask   = (inj_en && (INJ_ADDR_W'(addr_q) == inj_fld.addr))
                       ? (WORD_W'(1) << inj_fld.bit_idx) : '0;
    assign word        = mem_rdata ^ flip_mask;
    assign crc_nxt     = crc_fold(crc_q, word);
    assign par_bad     = (^word) != mem_par;
    assign addr_last   = (addr_q == LAST_ADDR);
    assign low_done    = (low_q == LOW_W'(LOW_TICKS - 1));
    assign search_done = par_bad || addr_last;

    always_comb begin
        pass_start = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE:   pass_start = init_done;
                ST_LOWP:   pass_start = low_done && !mism_q;
                ST_SEARCH: pass_start = search_done;
                default:   pass_start = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            crc_q     <= CRC_SEED;
            ref_q     <= '0;
            mism_q    <= 1'b0;
            low_q     <= '0;
            err_o     <= 1'b0;
            msg_valid <= 1'b0;
            msg_addr  <= '0;
        end else begin
            if (state_q == ST_IDLE) ref_q <= ref_crc;
            if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (init_done) begin
                            state_q <= ST_SCAN;
                            addr_q  <= '0;
                            crc_q   <= CRC_SEED;
                        end
                    end
                    ST_SCAN: begin
                        crc_q <= crc_nxt;
                        if (addr_last) begin
                            mism_q  <= (crc_nxt != ref_q);
                            state_q <= ST_LOWP;
                            low_q   <= '0;
                            err_o   <= 1'b0;
                            addr_q  <= '0;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    ST_LOWP: begin
                        if (low_done) begin
                            addr_q  <= '0;
                            crc_q   <= CRC_SEED;
                            state_q <= mism_q ? ST_SEARCH : ST_SCAN;
                        end else begin
                            low_q <= low_q + 1'b1;
                        end
                    end
                    ST_SEARCH: begin
                        if (search_done) begin
                            err_o     <= 1'b1;
                            msg_valid <= par_bad;
                            msg_addr  <= par_bad ? addr_q : '0;
                            state_q   <= ST_SCAN;
                            addr_q    <= '0;
                            crc_q     <= CRC_SEED;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Checker-side count of ticks spent with the error output low.
    logic [5:0] chk_low_q;
    always_ff @(posedge clk) begin
        if (rst || err_o)                    chk_low_q <= '0;
        else if (tick && chk_low_q != 6'h3F) chk_low_q <= chk_low_q + 1'b1;
    end

    // R3: the output never rises before a low stretch of the minimum length
    p_min_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (chk_low_q >= 6'(LOW_TICKS)));

    // R4: a rising error output only ever follows a location search
    p_rise_after_search_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> ($past(state_q) == ST_SEARCH));

    // R7: a located error is reported together with the error output
    p_msg_with_err_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> err_o);

    // R1: nothing moves before checking has begun
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!err_o && addr_q == '0));

endmodule

// File: rtl/scrub_crc_monitor.sv
module scrub_crc_monitor
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_done,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic [WORD_W-1:0]    ref_crc,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_par,
    input  logic                 tst_wr,
    input  logic [INJ_W-1:0]     tst_wdata,
    input  logic                 tst_upd,
    output logic                 err_o,
    output logic                 msg_valid,
    output logic [ADDR_W-1:0]    msg_addr
);

    logic       tick;
    logic       pass_start;
    logic       inj_en;
    inj_field_t inj_fld;

    scrub_clk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    scrub_fault_inj u_inj (
        .clk        (clk),
        .rst        (rst),
        .tst_wr     (tst_wr),
        .tst_wdata  (tst_wdata),
        .tst_upd    (tst_upd),
        .pass_start (pass_start),
        .act_en     (inj_en),
        .act_fld    (inj_fld)
    );

    scrub_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .init_done  (init_done),
        .ref_crc    (ref_crc),
        .mem_rdata  (mem_rdata),
        .mem_par    (mem_par),
        .inj_en     (inj_en),
        .inj_fld    (inj_fld),
        .mem_addr   (mem_addr),
        .pass_start (pass_start),
        .err_o      (err_o),
        .msg_valid  (msg_valid),
        .msg_addr   (msg_addr)
    );

endmodule

// File: tb/scrub_crc_monitor_tb.sv
`timescale 1ns/1ps
module scrub_crc_monitor_tb;

    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          init_done = 1'b0;
    logic [3:0]    div_sel = 4'd1;
    logic [31:0]   ref_crc = '0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          mem_par;
    logic          tst_wr = 1'b0;
    logic [20:0]   tst_wdata = '0;
    logic          tst_upd = 1'b0;
    logic          err_o;
    logic          msg_valid;
    logic [AW-1:0] msg_addr;

    logic [31:0] mem [NW];
    logic [31:0] golden;
    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mem_rdata = mem[mem_addr];
    assign mem_par   = ^mem[mem_addr];

    scrub_crc_monitor #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .init_done(init_done), .div_sel(div_sel),
        .ref_crc(ref_crc), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_par(mem_par), .tst_wr(tst_wr), .tst_wdata(tst_wdata),
        .tst_upd(tst_upd), .err_o(err_o), .msg_valid(msg_valid),
        .msg_addr(msg_addr)
    );

    function automatic logic [31:0] ref_crc_calc();
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 32; i++) begin
                if (((r ^ (mem[w] << i)) & 32'h8000_0000) != 0) r = (r << 1) ^ 32'h04C1_1DB7;
                else r = r << 1;
            end
        return r;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wait_err(input logic val, input longint limit, output longint t_hit);
        t_hit = -1;
        for (longint n = 0; n < limit; n++) begin
            @(negedge clk);
            if (err_o === val) begin
                t_hit = cyc;
                break;
            end
        end
    endtask

    task automatic do_reset(input logic [3:0] n, input logic [31:0] r);
        @(negedge clk);
        rst = 1'b1; init_done = 1'b0; div_sel = n; ref_crc = r;
        tst_wr = 1'b0; tst_upd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 err_o after reset", err_o, 0);
        chk("R9 msg_valid after reset", msg_valid, 0);
        chk("R9 msg_addr after reset", msg_addr, 0);
    endtask

    task automatic inject(input int a, input int b);
        @(negedge clk); tst_wr = 1'b1; tst_wdata = {16'(a), 5'(b)};
        @(negedge clk); tst_wr = 1'b0; tst_upd = 1'b1;
        @(negedge clk); tst_upd = 1'b0;
    endtask

    // Bad reference, injection armed for the third pass.
    task automatic run_bad_ref(input logic [3:0] n, input int d, input int k, input int b);
        longint t1, tf, tr;
        do_reset(n, golden ^ 32'h1);
        init_done = 1'b1;
        wait_err(1, 80 * d, t1);
        chk("R2 mismatch raises err_o", (t1 >= 0), 1);
        chk("R7 no located word, valid", msg_valid, 0);
        inject(k, b);
        wait_err(0, 80 * d, tf);
        chk("R8 scan length rise to fall", tf - t1, NW * d);
        wait_err(1, 80 * d, tr);
        chk("R3 R5 low time, search to last word", tr - tf, (32 + NW - 1) * d);
        chk("R7 valid without located word", msg_valid, 0);
        wait_err(0, 80 * d, tf);
        wait_err(1, 80 * d, tr);
        chk("R4 R6 low time to injected word", tr - tf, (32 + k) * d);
        chk("R7 msg_valid with located word", msg_valid, 1);
        chk("R7 msg_addr located word", msg_addr, k);
        wait_err(0, 80 * d, tf);
        wait_err(1, 80 * d, tr);
        chk("R6 injection disarmed after one pass", tr - tf, (32 + NW - 1) * d);
        chk("R6 R7 message cleared next pass", msg_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint t;
        int highs;
        for (int i = 0; i < NW; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ (32'(i) << 20);
        golden = ref_crc_calc();

        // R1: nothing happens until init_done
        do_reset(4'd1, golden ^ 32'h1);
        highs = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (err_o !== 1'b0 || mem_addr !== '0) highs++;
        end
        chk("R1 idle before init_done", highs, 0);
        init_done = 1'b1;
        wait_err(1, 200, t);
        chk("R1 checking starts after init_done", (t >= 0), 1);

        run_bad_ref(4'd1, 2, 5, 7);
        run_bad_ref(4'd3, 8, 15, 31);
        run_bad_ref(4'd0, 2, 0, 0);      // R5 clamp low
        run_bad_ref(4'd12, 256, 9, 13);  // R5 clamp high

        // R2 R10: correct reference, shadow written but never updated
        do_reset(4'd1, golden);
        @(negedge clk); tst_wr = 1'b1; tst_wdata = {16'd2, 5'd4};
        @(negedge clk); tst_wr = 1'b0;
        init_done = 1'b1;
        highs = 0;
        for (int i = 0; i < 6 * (NW + 33) * 2; i++) begin
            @(negedge clk);
            if (err_o !== 1'b0) highs++;
        end
        chk("R10 R2 clean passes keep err_o low", highs, 0);
        chk("R2 no message on clean passes", msg_valid, 0);

        // R6 R7 R8: injection on first pass, then clean passes
        do_reset(4'd2, golden);
        inject(3, 20);
        init_done = 1'b1;
        wait_err(1, 100 * 4, t);
        chk("R6 injected first pass raises err_o", (t >= 0), 1);
        chk("R7 msg_valid first pass", msg_valid, 1);
        chk("R7 msg_addr first pass", msg_addr, 3);
        wait_err(0, 100 * 4, t);
        chk("R8 clean pass drives err_o low", (t >= 0), 1);
        highs = 0;
        for (int i = 0; i < 3 * (NW + 33) * 4; i++) begin
            @(negedge clk);
            if (err_o !== 1'b0) highs++;
        end
        chk("R8 err_o stays low on clean passes", highs, 0);
        chk("R7 msg_valid holds", msg_valid, 1);
        chk("R7 msg_addr holds", msg_addr, 3);

        do_reset(4'd1, golden);
        finish_run();
    end

endmodule